// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 synchronous interrupt inputs into two 32-bit banks. Bank 0 holds sources 0 to 31 and bank 1 holds sources 32 to 63. Each source has a pending flag, which a high input sets and which holds after the input drops. Each source also has an enable bit. Its status bit is the pending flag ANDed with the enable bit. The OR of all status bits drives one interrupt line to the processor.

Two outputs carry the source to service first, a 7-bit index and a valid bit. Bank 0 always outranks bank 1. Within a bank, the lowest set status bit wins.

Software reaches the block over a simple single-cycle register bus. Writes take effect at the clock edge on which select and write are both high. Read data is combinational from the current register state. To acknowledge a source, software writes a 1 to its flag-clear bit. To mask or unmask a source, it rewrites the whole enable word.

Interrupt sources are handled as levels. A source that is still asserted sets its flag again after the acknowledge.

Top module: `irqc_top`

## Requirements
- R1: While reset is active, and after it is released, all flags and enables are 0. `irq_o` and `idx_vld_o` are low.
- R2: A source input that is high at a rising clock edge sets its flag. The flag stays set after the input drops, until it is acknowledged.
- R3: A write to the flag-clear word clears the flags whose data bit is 1. The flag-clear word is at byte offset 0x00 for bank 0 and 0x04 for bank 1. Flags whose data bit is 0 keep their value.
- R4: If a source is high in the same cycle as the acknowledge of its flag, the flag stays set. The set wins.
- R5: The enable words are at offset 0x10 for bank 0 and 0x14 for bank 1. Each is written as a whole word and reads back the value last written. Writing 0 to both disables every source.
- R6: Status bit n reads as flag n AND enable n. Status is at 0x18 for bank 0 and 0x1C for bank 1. Reading a flag-clear offset returns the raw flags of that bank.
- R7: `irq_o` is high exactly when at least one status bit is set.
- R8: `idx_o` gives the lowest set status bit of bank 0. If bank 0 status is all zero, it gives the lowest set status bit of bank 1 plus 32. `idx_vld_o` is high when any status bit is set. When it is low, `idx_o` is 0.
- R9: Reads from any offset other than the six listed return 0. Writes to the status offsets or to unmapped offsets change no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Synchronous interrupt source levels, bit n is source n |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, 0 when no read is selected |
| irq_o | output | 1 | Interrupt request to the processor |
| idx_o | output | 7 | Index of the highest-priority active source |
| idx_vld_o | output | 1 | Index is meaningful |

## Verification
The vector table drives the priority logic with several source patterns:
- a lone bank 1 source;
- sources in both banks, where bank 0 must win even at bit 31 against a lower bank 1 bit;
- several bits in one bank, where the lowest must win;
- patterns whose winning bit is masked, so the next enabled bit or bank 1 must take over;
- an all-masked pattern, which must give no request at all.

Each vector also reads back the raw flags and the status words. This separates a latching fault from a masking fault. Directed tests cover a partial acknowledge, which shows that zero bits are left alone. They also cover an acknowledge that coincides with an asserted source, writes to the read-only and unmapped offsets, and a reset in the middle of a run.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W      = 32;
  localparam int unsigned NBANK       = 2;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned OFS_CLR     = 'h00;
  localparam int unsigned OFS_EN      = 'h10;
  localparam int unsigned OFS_STAT    = 'h18;
  localparam int unsigned BANK_STRIDE = 4;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_FLAG = 2'd1,
    RK_EN   = 2'd2,
    RK_STAT = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/irqc_lsb_enc.sv
module irqc_lsb_enc #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] flag_q, flag_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    flag_d   = (flag_q & ~clr_mask) | src_i;
    en_d     = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_d;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign stat_o = flag_q & en_q;

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((flag_q & $past(src_i)) == $past(src_i)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((flag_q & $past(wdata_i) & ~$past(src_i)) == '0));

  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> (en_q == $past(en_q)));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [NB*W-1:0] flag_i,
  input  logic [NB*W-1:0] en_i,
  input  logic [NB*W-1:0] stat_i,
  output logic [NB-1:0]   clr_we_o,
  output logic [NB-1:0]   en_we_o,
  output logic [W-1:0]    rdata_o
);
  reg_kind_e       kind [NB];
  logic [NB-1:0]   hit;
  logic            wr_acc, rd_acc;

  assign wr_acc = sel_i && wr_i;
  assign rd_acc = sel_i && !wr_i;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR  + BANK_STRIDE * b);
    localparam logic [AW-1:0] A_EN   = AW'(OFS_EN   + BANK_STRIDE * b);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT + BANK_STRIDE * b);

    always_comb begin
      if (addr_i == A_CLR)       kind[b] = RK_FLAG;
      else if (addr_i == A_EN)   kind[b] = RK_EN;
      else if (addr_i == A_STAT) kind[b] = RK_STAT;
      else                       kind[b] = RK_NONE;
    end

    assign hit[b]      = (kind[b] != RK_NONE);
    assign clr_we_o[b] = wr_acc && (kind[b] == RK_FLAG);
    assign en_we_o[b]  = wr_acc && (kind[b] == RK_EN);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      for (int b = 0; b < NB; b++) begin
        case (kind[b])
          RK_FLAG: rdata_o = flag_i[b*W +: W];
          RK_EN:   rdata_o = en_i[b*W +: W];
          RK_STAT: rdata_o = stat_i[b*W +: W];
          default: ;
        endcase
      end
    end
  end

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_we_o, en_we_o}));

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (hit == '0)) |-> ((clr_we_o == '0) && (en_we_o == '0)));

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (hit == '0)) |-> (rdata_o == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned BW  = BANK_W,
  parameter int unsigned AW  = ADDR_W,
  localparam int unsigned NB = NBANK,
  localparam int unsigned SN = NB * BW,
  localparam int unsigned LW = $clog2(BW),
  localparam int unsigned IW = $clog2(SN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SN-1:0] src_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [BW-1:0] bus_wdata_i,
  output logic [BW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic [IW-1:0] idx_o,
  output logic          idx_vld_o
);
  logic          rst_n_s;
  logic [SN-1:0] flag_all, en_all, stat_all;
  logic [NB-1:0] clr_we, en_we;
  logic [LW-1:0] b_idx [NB];
  logic [NB-1:0] b_any;

  irqc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  irqc_regif #(.W(BW), .AW(AW), .NB(NB)) i_regif (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .flag_i   (flag_all),
    .en_i     (en_all),
    .stat_i   (stat_all),
    .clr_we_o (clr_we),
    .en_we_o  (en_we),
    .rdata_o  (bus_rdata_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irqc_bank #(.W(BW)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .src_i    (src_i[b*BW +: BW]),
      .clr_we_i (clr_we[b]),
      .en_we_i  (en_we[b]),
      .wdata_i  (bus_wdata_i),
      .flag_o   (flag_all[b*BW +: BW]),
      .en_o     (en_all[b*BW +: BW]),
      .stat_o   (stat_all[b*BW +: BW])
    );

    irqc_lsb_enc #(.W(BW)) i_enc (
      .vec_i (stat_all[b*BW +: BW]),
      .idx_o (b_idx[b]),
      .any_o (b_any[b])
    );
  end

  // Bank 0 outranks bank 1
  always_comb begin
    idx_o = '0;
    if (b_any[0])      idx_o = IW'(b_idx[0]);
    else if (b_any[1]) idx_o = IW'(b_idx[1]) + IW'(BW);
  end

  assign idx_vld_o = |b_any;
  assign irq_o     = |stat_all;

  p_vld_irq_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o == idx_vld_o);

  p_idx_lo_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (idx_vld_o && (idx_o < IW'(BW))) |-> stat_all[idx_o[LW-1:0]]);

  p_idx_hi_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (idx_vld_o && (idx_o >= IW'(BW))) |->
      ((stat_all[BW-1:0] == '0) && stat_all[BW + int'(idx_o[LW-1:0])]));

  p_idx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !idx_vld_o |-> (idx_o == '0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |-> (!irq_o && !idx_vld_o));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic        sel, wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, vld;
  logic [6:0]  idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .idx_o(idx), .idx_vld_o(vld)
  );

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] en;
    logic        vld;
    logic [6:0]  idx;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{src:64'h0000_0000_0000_0220, en:64'hFFFF_FFFF_FFFF_FFFF, vld:1'b1, idx:7'd5},
    '{src:64'h0000_0100_8000_0000, en:64'hFFFF_FFFF_FFFF_FFFF, vld:1'b1, idx:7'd31},
    '{src:64'h0000_0002_0000_0008, en:64'hFFFF_FFFF_0000_0000, vld:1'b1, idx:7'd33},
    '{src:64'h8000_0000_0000_0000, en:64'hFFFF_FFFF_FFFF_FFFF, vld:1'b1, idx:7'd63},
    '{src:64'h0000_0000_0000_0001, en:64'h0000_0000_0000_0000, vld:1'b0, idx:7'd0},
    '{src:64'h0004_0000_0000_00F0, en:64'h0000_0000_0000_0080, vld:1'b1, idx:7'd7},
    '{src:64'h0000_0001_0000_0001, en:64'hFFFF_FFFF_FFFF_FFFF, vld:1'b1, idx:7'd0},
    '{src:64'h0000_0001_0000_0001, en:64'hFFFF_FFFF_FFFF_FFFE, vld:1'b1, idx:7'd32}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic pulse_src(input logic [63:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  task automatic clear_all();
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq in reset", 64'(irq), 64'h0);
    chk("R1 vld in reset", 64'(vld), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(8'h10, d); chk("R1 en lo after reset", 64'(d), 64'h0);
    bus_read(8'h14, d); chk("R1 en hi after reset", 64'(d), 64'h0);
    bus_read(8'h00, d); chk("R1 flag lo after reset", 64'(d), 64'h0);
    #1 chk("R1 irq after reset", 64'(irq), 64'h0);

    // vector table: priority, masking, latching
    for (int v = 0; v < NV; v++) begin
      bus_write(8'h10, VECS[v].en[31:0]);
      bus_write(8'h14, VECS[v].en[63:32]);
      pulse_src(VECS[v].src);
      #1;
      chk($sformatf("R7 irq vec%0d", v), 64'(irq), 64'(VECS[v].vld));
      chk($sformatf("R8 vld vec%0d", v), 64'(vld), 64'(VECS[v].vld));
      chk($sformatf("R8 idx vec%0d", v), 64'(idx), 64'(VECS[v].idx));
      bus_read(8'h18, d);
      chk($sformatf("R6 stat lo vec%0d", v), 64'(d), 64'(VECS[v].src[31:0] & VECS[v].en[31:0]));
      bus_read(8'h1C, d);
      chk($sformatf("R6 stat hi vec%0d", v), 64'(d), 64'(VECS[v].src[63:32] & VECS[v].en[63:32]));
      bus_read(8'h00, d);
      chk($sformatf("R2 flag lo vec%0d", v), 64'(d), 64'(VECS[v].src[31:0]));
      bus_read(8'h04, d);
      chk($sformatf("R2 flag hi vec%0d", v), 64'(d), 64'(VECS[v].src[63:32]));
      clear_all();
    end

    // R3: partial acknowledge
    pulse_src(64'h0000_0000_0000_0006);
    bus_write(8'h00, 32'h0000_0002);
    bus_read(8'h00, d); chk("R3 partial ack", 64'(d), 64'h4);
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h00, d); chk("R3 zero write keeps", 64'(d), 64'h4);
    pulse_src(64'h0000_0010_0000_0000);
    bus_write(8'h04, 32'h0000_0001);
    bus_read(8'h04, d); chk("R3 hi ack other bit", 64'(d), 64'h10);
    clear_all();

    // R4: set wins over simultaneous acknowledge
    @(negedge clk);
    src = 64'h10; sel = 1'b1; wr = 1'b1; addr = 8'h00; wdata = 32'h10;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; src = '0;
    bus_read(8'h00, d); chk("R4 set wins", 64'(d), 64'h10);
    bus_write(8'h00, 32'h10);
    bus_read(8'h00, d); chk("R4 ack after drop", 64'(d), 64'h0);

    // R5: enable readback and global disable
    bus_write(8'h10, 32'h1234_5678);
    bus_write(8'h14, 32'h9ABC_DEF0);
    bus_read(8'h10, d); chk("R5 en lo readback", 64'(d), 64'h1234_5678);
    bus_read(8'h14, d); chk("R5 en hi readback", 64'(d), 64'h9ABC_DEF0);
    pulse_src(64'hFFFF_FFFF_FFFF_FFFF);
    #1 chk("R7 irq with enables", 64'(irq), 64'h1);
    chk("R8 idx masked pattern", 64'(idx), 64'd3);
    bus_write(8'h10, 32'h0);
    bus_write(8'h14, 32'h0);
    #1 chk("R5 all disabled irq", 64'(irq), 64'h0);
    chk("R8 vld all disabled", 64'(vld), 64'h0);

    // R9: read-only and unmapped offsets
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h10, d); chk("R9 stat write no en lo", 64'(d), 64'h0);
    bus_read(8'h14, d); chk("R9 stat write no en hi", 64'(d), 64'h0);
    bus_read(8'h00, d); chk("R9 stat write no flag lo", 64'(d), 64'hFFFF_FFFF);
    bus_read(8'h04, d); chk("R9 stat write no flag hi", 64'(d), 64'hFFFF_FFFF);
    bus_read(8'h08, d); chk("R9 unmapped 0x08", 64'(d), 64'h0);
    bus_read(8'h20, d); chk("R9 unmapped 0x20", 64'(d), 64'h0);
    bus_read(8'h11, d); chk("R9 unaligned 0x11", 64'(d), 64'h0);

    // R1: reset mid-run clears flags and enables
    bus_write(8'h10, 32'hFFFF_FFFF);
    #1 chk("R7 irq before reset", 64'(irq), 64'h1);
    rst_n = 1'b0;
    #2 chk("R1 irq async reset", 64'(irq), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(8'h00, d); chk("R1 flags after mid reset", 64'(d), 64'h0);
    bus_read(8'h10, d); chk("R1 en after mid reset", 64'(d), 64'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule